// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

A synchronous 8192 x 16 memory with two fully independent ports, called left and right. Each port has its own active-low chip select, write enable and output enable, plus its own address and data buses. While a port is selected it can read or write any word of the array. Read data appears one clock after the read request and is presented only while that port's output enable is low.

When the mailbox enable is high, the top two words of the array also carry signals between the two sides. A write from the right port to 0x1FFE raises the left port's interrupt. A write from the left port to 0x1FFF raises the right port's interrupt. Each side drops its own interrupt by reading its mailbox word. The mailbox words hold ordinary data that software chooses. When the enable is low, both words are plain RAM and both interrupts stay inactive. Same-address arbitration is handled by a neighbouring block and is not part of this one.

Top module: `dual_port_mailbox_ram`

## Requirements
- R1: A word written through either port is returned one clock later by a read of the same address from either port (cs low, we high), for any address, with all 16 bits intact.
- R2: A port with cs_n high writes nothing, and its read data register keeps its previous value.
- R3: The rdata output of a port is all zeros while its oe_n is high, and shows the registered read word while oe_n is low.
- R4: With the mailbox enabled, a right-port write to 0x1FFE drives l_int_no low after that clock edge. The flag returns high after the edge of a left-port read of 0x1FFE.
- R5: With the mailbox enabled, a left-port write to 0x1FFF drives r_int_no low after that clock edge. The flag returns high after the edge of a right-port read of 0x1FFF.
- R6: A port writing its own mailbox address does not change its own interrupt. That is, a left write to 0x1FFE leaves l_int_no unchanged, and a right write to 0x1FFF leaves r_int_no unchanged.
- R7: With the mailbox disabled, 0x1FFE and 0x1FFF behave as normal RAM and both interrupts are held inactive (high). A flag that is set is cleared at the next edge.
- R8: If a flag is set and cleared in the same cycle, it ends up set.
- R9: After reset both interrupts are high and both read data registers hold zero.
- R10: The data read back from a mailbox word is exactly the word that was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mbox_en_i | input | 1 | Mailbox interrupt enable |
| l_cs_ni | input | 1 | Left chip select, active low |
| l_we_ni | input | 1 | Left write enable, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | 13 | Left address |
| l_wdata_i | input | 16 | Left write data |
| l_rdata_o | output | 16 | Left read data |
| l_int_no | output | 1 | Left interrupt, active low |
| r_cs_ni | input | 1 | Right chip select, active low |
| r_we_ni | input | 1 | Right write enable, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | 13 | Right address |
| r_wdata_i | input | 16 | Right write data |
| r_rdata_o | output | 16 | Right read data |
| r_int_no | output | 1 | Right interrupt, active low |

## Verification
The assertions assume that the two ports never write the same address in the same cycle, because resolving that case belongs to the external arbiter. They also assume that control inputs are settled at each rising edge. The stimulus changes inputs only just after an edge. It never lets both ports write one address together. The only overlaps it creates are a write on one side with a read on the other, which is the case the set-over-clear rule is meant to cover.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } acc_t;

  localparam int unsigned N_PORTS = 2;
  localparam int unsigned P_LEFT  = 0;
  localparam int unsigned P_RIGHT = 1;
endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
  import dpm_pkg::*;
#(
  parameter int unsigned AW        = 13,
  parameter logic [AW-1:0] MBOX_A  = '1
) (
  input  logic          cs_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  output acc_t          acc_o,
  output logic          mbox_hit_o
);
  always_comb begin
    acc_o.rd = !cs_ni && we_ni;
    acc_o.wr = !cs_ni && !we_ni;
  end
  assign mbox_hit_o = (addr_i == MBOX_A);
endmodule

// File: rtl/dpm_ram_core.sv
module dpm_ram_core
  import dpm_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  acc_t    [N_PORTS-1:0]  acc_i,
  input  logic    [N_PORTS-1:0][AW-1:0] addr_i,
  input  logic    [N_PORTS-1:0][DW-1:0] wdata_i,
  output logic    [N_PORTS-1:0][DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // later port wins a same-address write; arbitration sits outside
  always_ff @(posedge clk_i) begin
    for (int p = 0; p < N_PORTS; p++) begin
      if (acc_i[p].wr) mem_q[addr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         rdata_o[p] <= '0;
      else if (acc_i[p].rd) rdata_o[p] <= mem_q[addr_i[p]];
    end

    AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acc_i[p].rd |=> $stable(rdata_o[p])); // R2
  end
endmodule

// File: rtl/dpm_mbox_flag.sv
module dpm_mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (!en_i)  flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && set_i |=> flag_o); // R8
  AST_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && clr_i && !set_i |=> !flag_o); // R4
  AST_DIS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !flag_o); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !set_i && !clr_i |=> $stable(flag_o)); // R6
endmodule

// File: rtl/dual_port_mailbox_ram.sv
module dual_port_mailbox_ram
  import dpm_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mbox_en_i,
  input  logic          l_cs_ni,
  input  logic          l_we_ni,
  input  logic          l_oe_ni,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_wdata_i,
  output logic [DW-1:0] l_rdata_o,
  output logic          l_int_no,
  input  logic          r_cs_ni,
  input  logic          r_we_ni,
  input  logic          r_oe_ni,
  input  logic [AW-1:0] r_addr_i,
  input  logic [DW-1:0] r_wdata_i,
  output logic [DW-1:0] r_rdata_o,
  output logic          r_int_no
);
  localparam logic [AW-1:0] TOP_A = '1;

  logic [N_PORTS-1:0]         cs_n, we_n, oe_n, hit, flag;
  logic [N_PORTS-1:0][AW-1:0] addr;
  logic [N_PORTS-1:0][DW-1:0] wdata, rdata_q;
  acc_t [N_PORTS-1:0]         acc;

  assign cs_n  = {r_cs_ni, l_cs_ni};
  assign we_n  = {r_we_ni, l_we_ni};
  assign oe_n  = {r_oe_ni, l_oe_ni};
  assign addr  = {r_addr_i, l_addr_i};
  assign wdata = {r_wdata_i, l_wdata_i};

  // port p owns mailbox at TOP_A-1+p: left 1FFE, right 1FFF
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    localparam logic [AW-1:0] OWN_A = TOP_A - AW'(N_PORTS - 1 - p);

    dpm_port_decode #(.AW(AW), .MBOX_A(OWN_A)) u_dec (
      .cs_ni      (cs_n[p]),
      .we_ni      (we_n[p]),
      .addr_i     (addr[p]),
      .acc_o      (acc[p]),
      .mbox_hit_o (hit[p])
    );
  end

  dpm_ram_core #(.AW(AW), .DW(DW)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata_q)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_flag
    localparam int unsigned OP = N_PORTS - 1 - p;
    localparam logic [AW-1:0] OWN_A = TOP_A - AW'(N_PORTS - 1 - p);
    logic peer_set;

    // peer writes this port's mailbox word
    assign peer_set = acc[OP].wr && (addr[OP] == OWN_A);

    dpm_mbox_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (mbox_en_i),
      .set_i  (peer_set),
      .clr_i  (acc[p].rd && hit[p]),
      .flag_o (flag[p])
    );
  end

  assign l_rdata_o = oe_n[P_LEFT]  ? '0 : rdata_q[P_LEFT];
  assign r_rdata_o = oe_n[P_RIGHT] ? '0 : rdata_q[P_RIGHT];
  assign l_int_no  = ~flag[P_LEFT];
  assign r_int_no  = ~flag[P_RIGHT];

  AST_L_SET_BY_PEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbox_en_i && !r_cs_ni && !r_we_ni && (r_addr_i == TOP_A - AW'(1)) |=> !l_int_no); // R4
  AST_R_SET_BY_PEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbox_en_i && !l_cs_ni && !l_we_ni && (l_addr_i == TOP_A) |=> !r_int_no); // R5
endmodule

// File: tb/sim_dual_port_mailbox_ram.sv
module sim_dual_port_mailbox_ram;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mbox_en_i = 1'b0;
  logic l_cs_ni = 1'b1, l_we_ni = 1'b1, l_oe_ni = 1'b0;
  logic r_cs_ni = 1'b1, r_we_ni = 1'b1, r_oe_ni = 1'b0;
  logic [12:0] l_addr_i = '0, r_addr_i = '0;
  logic [15:0] l_wdata_i = '0, r_wdata_i = '0;
  logic [15:0] l_rdata_o, r_rdata_o;
  logic l_int_no, r_int_no;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dual_port_mailbox_ram u0 (.*);

  localparam int NV = 7;
  localparam logic [28:0] VEC [NV] = '{
    {13'h0000, 16'h0001}, {13'h0005, 16'hA5A5}, {13'h0aaa, 16'h5A5A},
    {13'h1555, 16'hFFFF}, {13'h1FFD, 16'h8001}, {13'h1FFE, 16'h1357},
    {13'h1FFF, 16'h2468}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic lset(input logic cs, input logic we, input logic [12:0] a, input logic [15:0] d);
    l_cs_ni = cs; l_we_ni = we; l_addr_i = a; l_wdata_i = d;
  endtask

  task automatic rset(input logic cs, input logic we, input logic [12:0] a, input logic [15:0] d);
    r_cs_ni = cs; r_we_ni = we; r_addr_i = a; r_wdata_i = d;
  endtask

  task automatic idle();
    lset(1, 1, '0, '0); rset(1, 1, '0, '0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5; chk("R9 l_int", 16'(l_int_no), 16'h1);
    chk("R9 r_int", 16'(r_int_no), 16'h1);
    chk("R9 l_rdata", l_rdata_o, 16'h0);
    chk("R9 r_rdata", r_rdata_o, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1; tick();

    // table walk, mailbox off: plain RAM incl. top words
    for (int i = 0; i < NV; i++) begin
      lset(0, 0, VEC[i][28:16], VEC[i][15:0]); rset(1, 1, '0, '0); tick();
      chk("R7 r_int stays high", 16'(r_int_no), 16'h1);
      lset(1, 1, '0, '0); rset(0, 1, VEC[i][28:16], '0); tick();
      chk("R1 readback", r_rdata_o, VEC[i][15:0]);
      chk("R7 l_int stays high", 16'(l_int_no), 16'h1);
    end
    idle(); mbox_en_i = 1'b1; tick();

    // R2: deselected write ignored, deselected read holds
    rset(1, 0, 13'h0005, 16'hDEAD); tick();
    rset(1, 1, '0, '0); lset(0, 1, 13'h0005, '0); tick();
    chk("R2 no write when deselected", l_rdata_o, 16'hA5A5);
    lset(1, 1, 13'h0000, '0); tick();
    chk("R2 rdata holds when deselected", l_rdata_o, 16'hA5A5);

    // R3 output enable gating
    l_oe_ni = 1'b1; #1;
    chk("R3 oe high gives zero", l_rdata_o, 16'h0);
    l_oe_ni = 1'b0; #1;
    chk("R3 oe low shows data", l_rdata_o, 16'hA5A5);

    // R4 left flag set by right, cleared by left read
    rset(0, 0, 13'h1FFE, 16'h1234); tick();
    chk("R4 l_int set", 16'(l_int_no), 16'h0);
    chk("R4 r_int untouched", 16'(r_int_no), 16'h1);
    rset(1, 1, '0, '0); lset(0, 1, 13'h1FFE, '0); tick();
    chk("R4 l_int cleared", 16'(l_int_no), 16'h1);
    chk("R10 mailbox data", l_rdata_o, 16'h1234);

    // R5 right flag
    lset(0, 0, 13'h1FFF, 16'hBEEF); tick();
    chk("R5 r_int set", 16'(r_int_no), 16'h0);
    lset(1, 1, '0, '0); rset(0, 1, 13'h1FFF, '0); tick();
    chk("R5 r_int cleared", 16'(r_int_no), 16'h1);
    chk("R10 mailbox data", r_rdata_o, 16'hBEEF);

    // R6 own mailbox writes do not touch own flag
    rset(1, 1, '0, '0); lset(0, 0, 13'h1FFE, 16'h0F0F); tick();
    chk("R6 left own write", 16'(l_int_no), 16'h1);
    lset(1, 1, '0, '0); rset(0, 0, 13'h1FFF, 16'hF0F0); tick();
    chk("R6 right own write", 16'(r_int_no), 16'h1);

    // R8 set and clear same cycle
    rset(0, 0, 13'h1FFE, 16'h0001); tick();
    rset(0, 0, 13'h1FFE, 16'h0002); lset(0, 1, 13'h1FFE, '0); tick();
    chk("R8 set wins", 16'(l_int_no), 16'h0);
    rset(1, 1, '0, '0); tick();
    chk("R8 later read clears", 16'(l_int_no), 16'h1);

    // R7 disable drops a pending flag and blocks new ones
    lset(1, 1, '0, '0); rset(0, 0, 13'h1FFE, 16'h7777); tick();
    chk("R7 precondition set", 16'(l_int_no), 16'h0);
    idle(); mbox_en_i = 1'b0; tick();
    chk("R7 disable clears", 16'(l_int_no), 16'h1);
    rset(0, 0, 13'h1FFE, 16'h6666); tick();
    chk("R7 no set when off", 16'(l_int_no), 16'h1);
    rset(1, 1, '0, '0); lset(0, 1, 13'h1FFE, '0); tick();
    chk("R7 plain RAM when off", l_rdata_o, 16'h6666);
    idle(); tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule